// File: doc/BRIEF.md
# Double-Buffered Channel Attenuation Register Bank

This block holds the attenuation codes for six audio DAC channels, arranged as three stereo pairs, behind a simple address/data write port. Each channel keeps two registers. A staging register takes writes. A live register drives the channel's attenuation output. Software can stage new codes on several channels first and then make them take effect together. Any write that carries the commit flag copies every staging value into its live register on the same clock edge, so all six gains change at once.

A write to the master address stages one code into all six channels in a single access. When that write also carries the commit flag, the code takes effect on every channel immediately. Each code step is 0.5 dB of attenuation, and code 0xFF means no attenuation.

A one-cycle strobe marks each edge on which the live registers were refreshed, so that downstream gain logic knows when to resample. Converting codes to linear gain, applying gain to samples and the serial control bus are handled outside this block.

Top module: `vb_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active-low reset), every staging and live code becomes 0xFF and `upd_strobe` becomes 0.
- R2: An accepted write with `wr_data[8]`=0 stores `wr_data[7:0]` into the addressed channel's staging register only, and leaves every live code unchanged.
- R3: An accepted write with `wr_data[8]`=1 stores its code as in R2. On the same edge, every channel's live code takes that channel's new staging value, including the code just written.
- R4: Channel addresses are 0x14 to 0x19 in the order left 1, right 1, left 2, right 2, left 3, right 3 (channel index = address − 0x14). Channel i occupies bits [8i+7:8i] of `atten_out` and `stage_out`.
- R5: A write to 0x1C stores its code into all six staging registers. If `wr_data[8]`=1, all channels also commit on that edge.
- R6: A write to any other address changes no register and raises no strobe, even when `wr_data[8]`=1.
- R7: The commit flag is not stored. A later write with `wr_data[8]`=0 does not commit, even when it follows a committing write.
- R8: `upd_strobe` is high for exactly the one cycle that follows each committing edge, and is low otherwise.
- R9: With `wr_en` low, no register changes and no strobe is raised, whatever the address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Register address |
| wr_data | input | 9 | Bit 8 is the commit flag; bits 7:0 are the code |
| atten_out | output | 48 | Live attenuation codes, 8 bits per channel |
| stage_out | output | 48 | Readback of the staging codes, 8 bits per channel |
| upd_strobe | output | 1 | One-cycle pulse after each commit |

## Verification
Every result of a write is due on the rising edge that samples it. The staging readback, the live codes and the strobe all take their new values at that edge, with no extra latency. The bench drives each write on a falling edge, updates its reference model at the next rising edge, and compares every output at the following falling edge. Each result is therefore checked half a cycle after it is due, and before the next write can disturb it. Because the strobe must fall again one cycle later, comparing on every cycle also catches a pulse that lasts too long.

// File: rtl/vb_pkg.sv
package vb_pkg;
  localparam int CODE_W = 8;
  localparam int WORD_W = CODE_W + 1;

  typedef logic [CODE_W-1:0] code_t;

  // Attenuation code carried in a write word
  function automatic code_t word_code(input logic [WORD_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction

  // Commit flag carried in a write word
  function automatic logic word_commit(input logic [WORD_W-1:0] w);
    return w[CODE_W];
  endfunction

  // True when addr selects channel idx of a block based at base
  function automatic logic chan_match(input logic [7:0] addr,
                                      input logic [7:0] base,
                                      input int idx);
    return addr == (base + 8'(idx));
  endfunction
endpackage

// File: rtl/vb_decode.sv
module vb_decode #(
  parameter int NUM_CH      = 6,
  parameter logic [7:0] CH_BASE     = 8'h14,
  parameter logic [7:0] MASTER_ADDR = 8'h1C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [vb_pkg::WORD_W-1:0] wr_data,
  output logic [NUM_CH-1:0]  load_o,
  output logic               commit_o,
  output vb_pkg::code_t      code_o
);
  import vb_pkg::*;

  logic [NUM_CH-1:0] ch_hit;
  logic              master_hit;
  logic              addr_ok;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign ch_hit[i] = wr_en && chan_match(wr_addr, CH_BASE, i);
  end

  assign master_hit = wr_en && (wr_addr == MASTER_ADDR);
  assign addr_ok    = master_hit || (|ch_hit);
  assign load_o     = master_hit ? {NUM_CH{1'b1}} : ch_hit;
  assign commit_o   = addr_ok && word_commit(wr_data);
  assign code_o     = word_code(wr_data);

  // R4: at most one channel address matches
  a_r4_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_hit));
  // R6 / R9: no accepted address means no load and no commit
  a_r6_ignore_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_ok) |-> (load_o == '0 && !commit_o));
  // R5: master write loads every channel
  a_r5_master_all: assert property (@(posedge clk) disable iff (!rst_n)
    master_hit |-> (&load_o));
endmodule

// File: rtl/vb_channel.sv
module vb_channel #(
  parameter vb_pkg::code_t RESET_CODE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          commit_i,
  input  vb_pkg::code_t code_i,
  output vb_pkg::code_t stage_q,
  output vb_pkg::code_t live_q
);
  import vb_pkg::*;

  code_t stage_nxt;
  assign stage_nxt = load_i ? code_i : stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= RESET_CODE;
      live_q  <= RESET_CODE;
    end else begin
      stage_q <= stage_nxt;
      if (commit_i) live_q <= stage_nxt;
    end
  end

  // R2: without load the staging code holds
  a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(stage_q));
  // R3: after a commit the live code equals the staging code
  a_r3_live_follows: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (live_q == stage_q));
  // R7: without commit the live code holds
  a_r7_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(live_q));
endmodule

// File: rtl/vb_bank.sv
module vb_bank #(
  parameter int NUM_CH = 6,
  parameter logic [7:0] CH_BASE     = 8'h14,
  parameter logic [7:0] MASTER_ADDR = 8'h1C,
  parameter logic [7:0] RESET_CODE  = 8'hFF,
  localparam int CW    = vb_pkg::CODE_W,
  localparam int BUS_W = NUM_CH * CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [8:0]       wr_data,
  output logic [BUS_W-1:0] atten_out,
  output logic [BUS_W-1:0] stage_out,
  output logic             upd_strobe
);
  import vb_pkg::*;

  logic [NUM_CH-1:0] load_vec;
  logic              commit_ev;
  code_t             wr_code;

  vb_decode #(
    .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .MASTER_ADDR(MASTER_ADDR)
  ) i_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_o(load_vec), .commit_o(commit_ev),
    .code_o(wr_code)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    vb_channel #(.RESET_CODE(RESET_CODE)) i_ch (
      .clk(clk), .rst_n(rst_n), .load_i(load_vec[i]),
      .commit_i(commit_ev), .code_i(wr_code),
      .stage_q(stage_out[i*CW +: CW]),
      .live_q(atten_out[i*CW +: CW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upd_strobe <= 1'b0;
    else        upd_strobe <= commit_ev;
  end

  // R8: strobe follows each commit for one cycle
  a_r8_strobe_on: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> upd_strobe);
  a_r8_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> !upd_strobe);
  // R3: a commit leaves the whole live bank equal to the staging bank
  a_r3_bank_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> (atten_out == stage_out));
  // R9: an idle port changes nothing
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(atten_out) && $stable(stage_out)));
endmodule

// File: tb/test_vb_bank.sv
module test_vb_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [8:0]  wr_data = 0;
  logic [47:0] atten_out, stage_out;
  logic        upd_strobe;

  int n_cmp = 0, n_bad = 0;
  int m_stage[6], m_live[6];
  int m_strobe = 0;
  bit done = 0;

  vb_bank i_vb_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .atten_out(atten_out), .stage_out(stage_out),
    .upd_strobe(upd_strobe)
  );

  always #5 clk = ~clk;

  task automatic model_reset();
    for (int i = 0; i < 6; i++) begin m_stage[i] = 255; m_live[i] = 255; end
    m_strobe = 0;
  endtask

  // Behavioural model of one accepted edge
  task automatic model_step(input bit en, input int addr, input int data);
    bit hit = 0;
    int code = data % 256;
    bit flag = (data / 256) % 2;
    m_strobe = 0;
    if (en) begin
      if (addr >= 'h14 && addr <= 'h19) begin m_stage[addr - 'h14] = code; hit = 1; end
      else if (addr == 'h1C) begin
        for (int i = 0; i < 6; i++) m_stage[i] = code;
        hit = 1;
      end
      if (hit && flag) begin
        for (int i = 0; i < 6; i++) m_live[i] = m_stage[i];
        m_strobe = 1;
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int i = 0; i < 6; i++) begin
      n_cmp++;
      if (int'(atten_out[i*8 +: 8]) != m_live[i]) begin
        n_bad++;
        $display("FAIL %s live ch%0d actual %0h expected %0h", tag, i, atten_out[i*8 +: 8], m_live[i]);
      end
      n_cmp++;
      if (int'(stage_out[i*8 +: 8]) != m_stage[i]) begin
        n_bad++;
        $display("FAIL %s stage ch%0d actual %0h expected %0h", tag, i, stage_out[i*8 +: 8], m_stage[i]);
      end
    end
    n_cmp++;
    if (int'(upd_strobe) != m_strobe) begin
      n_bad++;
      $display("FAIL %s strobe actual %0d expected %0d", tag, upd_strobe, m_strobe);
    end
  endtask

  task automatic cycle(input bit en, input int addr, input int data, input string tag);
    @(negedge clk);
    wr_en = en; wr_addr = 8'(addr); wr_data = 9'(data);
    @(posedge clk);
    model_step(en, addr, data);
    @(negedge clk);
    wr_en = 0;
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lfsr = 'hACE1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    // R2: stage only
    cycle(1, 'h14, 'h020, "R2 stage left1");
    cycle(0, 0, 0, "R8 strobe idle");
    // R4: every channel address in turn, no commit
    for (int i = 0; i < 6; i++) cycle(1, 'h14 + i, 'h30 + i, "R4 map");
    // R3: commit with a write to right 2
    cycle(1, 'h17, 'h155, "R3 commit all");
    // R7 / R8: next write without flag must not commit, strobe drops
    cycle(1, 'h18, 'h011, "R7 flag not kept");
    // R5: master stage then master commit
    cycle(1, 'h1C, 'h080, "R5 master stage");
    cycle(1, 'h1C, 'h1A0, "R5 master commit");
    // R6: unlisted addresses with flag set
    cycle(1, 'h1A, 'h1EE, "R6 ignore 1A");
    cycle(1, 'h1B, 'h1EE, "R6 ignore 1B");
    cycle(1, 'h13, 'h1EE, "R6 ignore 13");
    cycle(1, 'h1D, 'h1EE, "R6 ignore 1D");
    // R9: wr_en low with a valid address and flag
    cycle(0, 'h14, 'h1EE, "R9 no enable");
    cycle(0, 'h1C, 'h100, "R9 no enable master");
    // Mid-reset check
    @(negedge clk); rst_n = 0;
    @(posedge clk); model_reset();
    @(negedge clk); compare("R1 mid reset"); rst_n = 1;
    // Mixed pseudo-random traffic
    for (int k = 0; k < 300; k++) begin
      int a;
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0)) & 'hFFFF;
      a = 'h12 + (lfsr % 12);
      cycle((lfsr / 4096) % 8 != 0, a, (lfsr / 16) % 512, "R3 R5 mixed");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule